// File: doc/BRIEF.md
# Stop-Mode Wake Clock Controller

This block decides how the core clock comes back after the device has been put into a low-power stop state. A stop request halts the core. A later wake event restarts it in one of two ways. In the slow way the core stays held until the crystal reports that its warm-up is done. In the fast way the core runs at once from an internal ring oscillator and moves to the crystal when the crystal is warm. The clock source is given as a select output. The oscillators and the glitch-free clock switch are outside the block.

Two control bits set the behaviour. `ring_sel` picks the fast wake path. `ref_in_stop` keeps the bandgap reference powered while stopped. Both bits can change only inside a short window that a timed-access unlock strobe opens. `ring_sel` is cleared by a power-on reset only, so it survives every other reset. `ref_in_stop` is cleared by any reset. When the reference is off during stop, power-fail requests are blocked for as long as the block is stopped.

The controller has three states:
- RUN: the core is clocked.
- STOPPED: the core is halted, waiting for a wake event.
- WARMING: the core is held until the crystal is ready.

It has these transitions:
- RUN to STOPPED on a stop request.
- STOPPED to RUN on a wake event, on the ring oscillator if `ring_sel` is set, or on the crystal if the crystal is already warm.
- STOPPED to WARMING on a wake event when `ring_sel` is clear and the crystal is not ready.
- WARMING to RUN when the crystal is ready.
- Inside RUN, the ring-to-crystal handover happens when the crystal is ready.

Top module: `stop_wake_clkctl`

## Requirements
- R1: After any reset the block is in RUN with `core_run`=1, `clk_sel`=0 (crystal) and `bg_en`=1. After a power-on reset `ctrl_rd` reads 2'b00.
- R2: A `stop_req` sampled high in RUN gives `core_run`=0 from the next cycle on. If `stop_req` and `wake_evt` are high together in RUN, the stop wins.
- R3: With `ring_sel`=0, a wake while `xtal_ready` is low enters WARMING. `core_run` stays 0 until `xtal_ready` is sampled high. `core_run` is 1 in the cycle after that sample, with `clk_sel`=0.
- R4: With `ring_sel`=1, a wake while `xtal_ready` is low gives `core_run`=1 and `clk_sel`=1 (ring) in the next cycle. `clk_sel` returns to 0 in the cycle after `xtal_ready` is sampled high in RUN.
- R5: A wake while `xtal_ready` is already high gives RUN on the crystal (`clk_sel`=0) in the next cycle, whatever the value of `ring_sel`.
- R6: A `wake_evt` in RUN while the crystal is selected changes neither `core_run` nor `clk_sel`.
- R7: `ring_sel` (bit 1 of `ctrl_rd`) clears only on a power-on reset (`por_n` low). A pulse on `rst_n` leaves it unchanged.
- R8: `bg_en` is 0 in STOPPED when `ref_in_stop` (bit 0 of `ctrl_rd`) is 0, and 1 in every other case. `ref_in_stop` clears on any reset.
- R9: `pf_req_out` follows `pf_req_in`, except that it is 0 while STOPPED with `ref_in_stop`=0.
- R10: A `ta_strobe` sampled at edge e opens a window. A write (`wr_en` with `wr_data`, where bit 1 is the ring select and bit 0 is the reference enable) is taken at edges e+1 to e+UNLOCK_CYC, and a taken write closes the window. Writes at any other edge leave `ctrl_rd` unchanged.
- R11: `ctrl_rd` shows the control register as {ring select, reference enable} in the cycle after each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Any other reset source, active low, synchronous |
| stop_req | input | 1 | Request to enter stop |
| wake_evt | input | 1 | Wake event out of stop |
| xtal_ready | input | 1 | Crystal warm-up done |
| pf_req_in | input | 1 | Raw power-fail request |
| ta_strobe | input | 1 | Timed-access unlock strobe |
| wr_en | input | 1 | Control register write |
| wr_data | input | 2 | {ring select, reference enable} |
| core_run | output | 1 | Core clock enable |
| clk_sel | output | 1 | 0 = crystal, 1 = ring oscillator |
| bg_en | output | 1 | Bandgap reference enable |
| pf_req_out | output | 1 | Gated power-fail request |
| ctrl_rd | output | 2 | Control register read-back |

## Verification
The hardest state to reach is the ring-oscillator run after a wake. To get there, the bench must first pass a timed write that sets `ring_sel`, then put the block into stop, and only then raise the wake while `xtal_ready` is held low. Holding `xtal_ready` low is what exposes the ring phase before the handover. The same ring setting is then carried through an `rst_n` pulse and a second stop/wake, which shows that the bit persists. A reference model advanced on every edge compares all outputs each cycle, so every transition along these paths is checked.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_WARMING = 2'd2
    } swc_state_e;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_RING = 1'b1
    } swc_src_e;

    typedef struct packed {
        logic ring_sel;
        logic ref_in_stop;
    } swc_ctrl_t;
endpackage

// File: rtl/swc_unlock.sv
module swc_unlock #(
    parameter int UNLOCK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ta_strobe,
    input  logic wr_en,
    output logic wr_ok
);
    localparam int CW = $clog2(UNLOCK_CYC + 1);

    logic [CW-1:0] win_cnt;

    assign wr_ok = wr_en && (win_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (ta_strobe)
            win_cnt <= CW'(UNLOCK_CYC);
        else if (wr_ok)
            win_cnt <= '0;
        else if (win_cnt != '0)
            win_cnt <= win_cnt - 1'b1;
    end

    AST_WINDOW_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !ta_strobe) |=> !wr_ok); // R10
    AST_STROBE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_strobe && !wr_ok) |=> (wr_en -> wr_ok)); // R10
endmodule

// File: rtl/swc_ctrl_reg.sv
module swc_ctrl_reg
    import swc_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      rst_n,
    input  logic      wr_ok,
    input  swc_ctrl_t wr_data,
    output swc_ctrl_t ctrl_q
);
    // Ring select: cleared by power-on reset only
    always_ff @(posedge clk) begin
        if (!por_n)
            ctrl_q.ring_sel <= 1'b0;
        else if (rst_n && wr_ok)
            ctrl_q.ring_sel <= wr_data.ring_sel;
    end

    // Reference enable: cleared by any reset
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            ctrl_q.ref_in_stop <= 1'b0;
        else if (wr_ok)
            ctrl_q.ref_in_stop <= wr_data.ref_in_stop;
    end

    AST_SEL_SURVIVES_RST: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> $stable(ctrl_q.ring_sel)); // R7
    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!wr_ok) |=> $stable(ctrl_q)); // R10
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake_evt,
    input  logic xtal_ready,
    input  logic ring_sel,
    input  logic ref_in_stop,
    input  logic pf_req_in,
    output logic core_run,
    output logic clk_sel,
    output logic bg_en,
    output logic pf_req_out
);
    swc_state_e state_q, state_d;
    swc_src_e   src_q, src_d;

    // Next state and clock source
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req)
                    state_d = ST_STOPPED;
                else if (src_q == SRC_RING && xtal_ready)
                    src_d = SRC_XTAL;
            end
            ST_STOPPED: begin
                if (wake_evt) begin
                    if (xtal_ready) begin
                        state_d = ST_RUN;
                        src_d   = SRC_XTAL;
                    end else if (ring_sel) begin
                        state_d = ST_RUN;
                        src_d   = SRC_RING;
                    end else begin
                        state_d = ST_WARMING;
                        src_d   = SRC_XTAL;
                    end
                end
            end
            ST_WARMING: begin
                if (xtal_ready)
                    state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
                src_d   = SRC_XTAL;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= SRC_XTAL;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // Outputs
    always_comb begin
        core_run   = (state_q == ST_RUN);
        clk_sel    = src_q;
        bg_en      = (state_q != ST_STOPPED) || ref_in_stop;
        pf_req_out = pf_req_in && bg_en;
    end

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req) |=> !core_run); // R2
    AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARMING && !xtal_ready) |=> (!core_run && clk_sel == SRC_XTAL)); // R3
    AST_RING_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && wake_evt && ring_sel && !xtal_ready)
        |=> (core_run && clk_sel == SRC_RING)); // R4
    AST_XTAL_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && clk_sel == SRC_RING && xtal_ready && !stop_req)
        |=> (core_run && clk_sel == SRC_XTAL)); // R4
    AST_WARM_WAKE_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && wake_evt && xtal_ready)
        |=> (core_run && clk_sel == SRC_XTAL)); // R5
    AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && clk_sel == SRC_XTAL && wake_evt && !stop_req)
        |=> (core_run && clk_sel == SRC_XTAL)); // R6
    AST_PF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !ref_in_stop) |-> (!bg_en && !pf_req_out)); // R9
endmodule

// File: rtl/stop_wake_clkctl.sv
module stop_wake_clkctl
    import swc_pkg::*;
#(
    parameter int UNLOCK_CYC = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake_evt,
    input  logic       xtal_ready,
    input  logic       pf_req_in,
    input  logic       ta_strobe,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic       core_run,
    output logic       clk_sel,
    output logic       bg_en,
    output logic       pf_req_out,
    output logic [1:0] ctrl_rd
);
    logic      any_rst_n;
    logic      wr_ok;
    swc_ctrl_t ctrl_q;

    assign any_rst_n = por_n && rst_n;
    assign ctrl_rd   = ctrl_q;

    swc_unlock #(.UNLOCK_CYC(UNLOCK_CYC)) u_unlock (
        .clk       (clk),
        .rst_n     (any_rst_n),
        .ta_strobe (ta_strobe),
        .wr_en     (wr_en),
        .wr_ok     (wr_ok)
    );

    swc_ctrl_reg u_ctrl (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_data (swc_ctrl_t'(wr_data)),
        .ctrl_q  (ctrl_q)
    );

    swc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (any_rst_n),
        .stop_req    (stop_req),
        .wake_evt    (wake_evt),
        .xtal_ready  (xtal_ready),
        .ring_sel    (ctrl_q.ring_sel),
        .ref_in_stop (ctrl_q.ref_in_stop),
        .pf_req_in   (pf_req_in),
        .core_run    (core_run),
        .clk_sel     (clk_sel),
        .bg_en       (bg_en),
        .pf_req_out  (pf_req_out)
    );

    AST_RESET_RUN: assert property (@(posedge clk)
        (!any_rst_n) |=> (core_run && !clk_sel && bg_en)); // R1
endmodule

// File: tb/tb_stop_wake_clkctl.sv
`timescale 1ns/1ps
module tb_stop_wake_clkctl;
    localparam int UNLOCK_CYC = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b1;
    logic stop_req = 1'b0, wake_evt = 1'b0, xtal_ready = 1'b0, pf_req_in = 1'b0;
    logic ta_strobe = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic core_run, clk_sel, bg_en, pf_req_out;
    logic [1:0] ctrl_rd;

    int n_tests = 0, n_fail = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    // Reference model state
    int m_state = 0;   // 0 run, 1 stopped, 2 warming
    int m_src   = 0;   // 0 crystal, 1 ring
    int m_ring  = 0;
    int m_ref   = 0;
    int m_win   = 0;

    always #4 clk = ~clk;  // 125 MHz

    stop_wake_clkctl #(.UNLOCK_CYC(UNLOCK_CYC)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .stop_req(stop_req),
        .wake_evt(wake_evt), .xtal_ready(xtal_ready), .pf_req_in(pf_req_in),
        .ta_strobe(ta_strobe), .wr_en(wr_en), .wr_data(wr_data),
        .core_run(core_run), .clk_sel(clk_sel), .bg_en(bg_en),
        .pf_req_out(pf_req_out), .ctrl_rd(ctrl_rd)
    );

    always @(posedge clk) begin
        int ns, nsrc, nring, nref, nwin;
        bit accept;
        ns = m_state; nsrc = m_src; nring = m_ring; nref = m_ref; nwin = m_win;
        if (!por_n || !rst_n) begin
            ns = 0; nsrc = 0; nref = 0; nwin = 0;
            if (!por_n) nring = 0;
        end else begin
            accept = wr_en && (m_win > 0);
            if (accept) begin nring = wr_data[1]; nref = wr_data[0]; end
            if (ta_strobe) nwin = UNLOCK_CYC;
            else if (accept) nwin = 0;
            else if (m_win > 0) nwin = m_win - 1;
            if (m_state == 0) begin
                if (stop_req) ns = 1;
                else if (m_src == 1 && xtal_ready) nsrc = 0;
            end else if (m_state == 1) begin
                if (wake_evt) begin
                    if (xtal_ready) begin ns = 0; nsrc = 0; end
                    else if (m_ring == 1) begin ns = 0; nsrc = 1; end
                    else begin ns = 2; nsrc = 0; end
                end
            end else if (xtal_ready) ns = 0;
        end
        m_state <= ns; m_src <= nsrc; m_ring <= nring; m_ref <= nref; m_win <= nwin;
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Full comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            int ebg;
            ebg = (m_state != 1 || m_ref == 1) ? 1 : 0;
            chk("R2 R3 core_run", int'(core_run), (m_state == 0) ? 1 : 0);
            chk("R4 R5 clk_sel", int'(clk_sel), m_src);
            chk("R8 bg_en", int'(bg_en), ebg);
            chk("R9 pf_req_out", int'(pf_req_out), int'(pf_req_in) & ebg);
            chk("R11 ctrl_rd", int'(ctrl_rd), m_ring * 2 + m_ref);
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic twrite(logic [1:0] d);
        ta_strobe = 1'b1; step(); ta_strobe = 1'b0;
        wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(2);
        cmp_on = 1'b1;
        por_n = 1'b1; step();
        chk("R1 reset core_run", int'(core_run), 1);
        chk("R1 reset clk_sel", int'(clk_sel), 0);
        chk("R1 reset bg_en", int'(bg_en), 1);
        chk("R1 reset ctrl_rd", int'(ctrl_rd), 0);

        // R10: write without unlock ignored
        wr_en = 1'b1; wr_data = 2'b11; step(); wr_en = 1'b0;
        chk("R10 locked write", int'(ctrl_rd), 0);
        // R10: write after window expired ignored
        ta_strobe = 1'b1; step(); ta_strobe = 1'b0;
        step(UNLOCK_CYC);
        wr_en = 1'b1; wr_data = 2'b11; step(); wr_en = 1'b0;
        chk("R10 late write", int'(ctrl_rd), 0);
        // R10: write on last open edge accepted, second write in window rejected
        ta_strobe = 1'b1; step(); ta_strobe = 1'b0;
        step(UNLOCK_CYC - 1);
        wr_en = 1'b1; wr_data = 2'b01; step();
        chk("R10 last slot write", int'(ctrl_rd), 1);
        wr_data = 2'b10; step(); wr_en = 1'b0;
        chk("R10 window closed after use", int'(ctrl_rd), 1);

        // ref=1 ring=0: stop keeps bandgap, slow wake
        pf_req_in = 1'b1;
        stop_req = 1'b1; step(); stop_req = 1'b0; step();
        chk("R2 stopped", int'(core_run), 0);
        chk("R8 bg kept in stop", int'(bg_en), 1);
        chk("R9 pf passes", int'(pf_req_out), 1);
        wake_evt = 1'b1; step(); wake_evt = 1'b0; step(3);
        chk("R3 warming held", int'(core_run), 0);
        xtal_ready = 1'b1; step();
        chk("R3 run after warm", int'(core_run), 1);
        chk("R3 crystal", int'(clk_sel), 0);
        xtal_ready = 1'b0;

        // ring=1 ref=0: fast wake
        twrite(2'b10);
        stop_req = 1'b1; step(); stop_req = 1'b0; step();
        chk("R8 bg off in stop", int'(bg_en), 0);
        chk("R9 pf blocked", int'(pf_req_out), 0);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R4 ring start run", int'(core_run), 1);
        chk("R4 ring selected", int'(clk_sel), 1);
        chk("R9 pf back", int'(pf_req_out), 1);
        step(2);
        xtal_ready = 1'b1; step();
        chk("R4 handover", int'(clk_sel), 0);
        wake_evt = 1'b1; step(); wake_evt = 1'b0; step();
        chk("R6 wake in run", int'(clk_sel) * 2 + int'(core_run), 1);

        // R5: wake with crystal already warm
        stop_req = 1'b1; step(); stop_req = 1'b0;
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R5 direct crystal", int'(clk_sel) * 2 + int'(core_run), 1);
        xtal_ready = 1'b0;

        // R2: stop wins over wake
        stop_req = 1'b1; wake_evt = 1'b1; step();
        stop_req = 1'b0; wake_evt = 1'b0;
        chk("R2 stop priority", int'(core_run), 0);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R4 ring again", int'(clk_sel), 1);

        // R7: rst_n keeps ring select, por clears it
        twrite(2'b11);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step();
        chk("R7 ring survives rst_n", int'(ctrl_rd), 2);
        chk("R1 rst_n back to run", int'(core_run) * 2 + int'(clk_sel), 2);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R7 ring used after rst_n", int'(clk_sel), 1);
        por_n = 1'b0; step(); por_n = 1'b1; step();
        chk("R7 por clears ring", int'(ctrl_rd), 0);

        step(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule